// File: doc/BRIEF.md
# Power Management Event and SMI Controller

This block gathers wake-up and status events from a portable system's external signals and raises a System Management Interrupt toward the CPU. Each input is synchronized. It then passes through an edge detector that suits that input. Mechanical switches and connector-sense lines are filtered first, so that a new level is accepted only after it holds for four consecutive sample ticks. Alarm, floppy DMA and ring inputs skip the filter. They act only while the power state logic reports a low-power (doze or sleep) state. The ring input passes through a counter, so that a programmed number of rings is needed to wake the system.

Two battery-sense levels drive a staged warning scheme. The first stage repeats its interrupt at a programmed tick interval while only the first-stage input is low. Once the second-stage input goes low, only the second stage repeats. Every source owns a sticky status bit that a write-one-to-clear strobe clears. The interrupt pin is driven in one of three release modes. Its active level can be selected, and an external interrupt request is ORed in.

The block is placed beside the register bank and the power state machine. Those supply the settings and the low-power flag. The block returns the status vector, the interrupt pin and a wake pulse.

Top module: `pm_smi_ctrl`

## Requirements
- R1: For each filtered event input `evt_i[k]` (k from 0 to NB-1), an accepted rising level and an accepted falling level each set status bit k.
- R2: A level change on a filtered input that holds for fewer than 4 consecutive sample ticks sets no status bit; one that holds for 4 ticks is accepted.
- R3: The active-low hotkey input sets status bit NB on an accepted falling edge only; its rising edge sets nothing.
- R4: A rising edge on the alarm input (bit NB+1) or the DMA-request input (bit NB+2) sets its bit and pulses `wake_o` only while `sys_asleep_i` is 1; while it is 0 the edge has no effect.
- R5: While asleep, ring rising edges are counted, and the edge that brings the count to `ring_target_i` sets bit NB+3, pulses `wake_o` and restarts the count; while awake the count is held at zero.
- R6: While `lb_n_i` is low and `llb_n_i` is high, bit NB+4 is set once every `batt_intv_i` ticks; with both inputs high no battery bit is ever set.
- R7: While `llb_n_i` is low, bit NB+5 is set once every `batt_intv_i` ticks and bit NB+4 is never set.
- R8: Status bits are sticky; a cycle with `clr_stb_i` high clears exactly the bits whose `clr_mask_i` bit is 1, and a set in the same cycle wins.
- R9: Mode 0 holds the internal interrupt active while any status bit is set, and drops it the cycle after the last bit clears.
- R10: Mode 1 sets the interrupt on a new event and drops it at the earlier of all status cleared or `smi_len_i` ticks; with one tick per cycle it stays active exactly `smi_len_i` cycles when not cleared.
- R11: Modes 2 and 3 drive a pulse exactly `smi_len_i` ticks long per event, independent of status.
- R12: `smi_o` equals (internal active OR `ext_smi_i`) when `smi_act_high_i` is 1, and its inverse when 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slow sample/timer tick, one cycle wide |
| sys_asleep_i | input | 1 | 1 while the system is in doze or sleep |
| evt_i | input | NB | Filtered both-edge event inputs (AC, lid, mouse, CRT, setup, eject, dock) |
| hotkey_n_i | input | 1 | Active-low hotkey |
| rtc_i | input | 1 | Alarm wake input |
| drq_i | input | 1 | Floppy DMA request wake input |
| ring_i | input | 1 | Modem ring input |
| lb_n_i | input | 1 | Active-low first battery warning |
| llb_n_i | input | 1 | Active-low second battery warning |
| ext_smi_i | input | 1 | External interrupt request, ORed into the pin |
| ring_target_i | input | RW | Ring count that raises a wake |
| batt_intv_i | input | TW | Battery repeat interval in ticks |
| smi_mode_i | input | 2 | 0 hold, 1 hold with timeout, 2/3 pulse |
| smi_len_i | input | TW | Timeout / pulse length in ticks |
| smi_act_high_i | input | 1 | 1 selects active-high interrupt pin |
| clr_stb_i | input | 1 | Status clear strobe |
| clr_mask_i | input | NB+6 | Bits cleared by the strobe |
| status_o | output | NB+6 | Sticky status vector |
| wake_o | output | 1 | One-cycle wake request pulse |
| smi_o | output | 1 | System Management Interrupt pin |

## Verification
Filtered inputs are driven with clean steps in both directions and with a three-cycle glitch, which separates the accept threshold from plain edge detection. The hotkey is stepped both ways to confirm its single edge. The alarm, DMA and ring inputs are pulsed with the low-power flag in each state, and ring pulses are split across an awake interval to show the counter restart. Battery levels are stepped through normal, first-stage and second-stage, and each of the three release modes is run with and without a status clear so that the pulse lengths show which event ended the interrupt.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } pm_edge_e;

   typedef enum logic [1:0] {
      SMI_HOLD      = 2'd0,
      SMI_HOLD_TMO  = 2'd1,
      SMI_PULSE     = 2'd2,
      SMI_PULSE_ALT = 2'd3
   } smi_mode_e;
endpackage

// File: rtl/pm_in_filter.sv
module pm_in_filter #(
   parameter bit DEBOUNCE = 1'b1,
   parameter int DB_TICKS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic raw_i,
   output logic lvl_o,
   output logic vld_o
);
   localparam int CW = $clog2(DB_TICKS) + 1;

   logic s1_q, s2_q, lvl_q, primed_q;

   initial assert (DB_TICKS >= 2) else $error("DB_TICKS must be at least 2");

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= raw_i;
         s2_q <= s1_q;
      end
   end

   generate
      if (DEBOUNCE) begin : g_db
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               cnt_q    <= '0;
               lvl_q    <= 1'b0;
               primed_q <= 1'b0;
            end else if (tick_i) begin
               if (!primed_q) begin
                  lvl_q    <= s2_q;
                  primed_q <= 1'b1;
                  cnt_q    <= '0;
               end else if (s2_q == lvl_q) begin
                  cnt_q <= '0;
               end else if (cnt_q == CW'(DB_TICKS - 1)) begin
                  lvl_q <= s2_q;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         // R2: an accepted level only moves on a tick and always to the synced input
         p_level_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lvl_q != $past(lvl_q)) |-> ($past(tick_i) && lvl_q == $past(s2_q)));
      end else begin : g_direct
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               lvl_q    <= 1'b0;
               primed_q <= 1'b0;
            end else begin
               lvl_q    <= s2_q;
               primed_q <= primed_q | tick_i;
            end
         end
      end
   endgenerate

   assign lvl_o = lvl_q;
   assign vld_o = primed_q;
endmodule

// File: rtl/pm_edge_pick.sv
module pm_edge_pick import pm_smi_pkg::*; #(
   parameter pm_edge_e EDGE = EDGE_BOTH
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic vld_i,
   output logic pulse_o
);
   logic prev_q, armed_q, rise, fall;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= lvl_i;
         armed_q <= vld_i;
      end
   end

   assign rise = armed_q & ~prev_q & lvl_i;
   assign fall = armed_q & prev_q & ~lvl_i;

   generate
      if (EDGE == EDGE_RISE) begin : g_rise
         assign pulse_o = rise;
      end else if (EDGE == EDGE_FALL) begin : g_fall
         assign pulse_o = fall;
      end else if (EDGE == EDGE_BOTH) begin : g_both
         assign pulse_o = rise | fall;
      end else begin : g_none
         assign pulse_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pm_batt_warn.sv
module pm_batt_warn #(
   parameter int TW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          lb_lvl_i,
   input  logic          lb_vld_i,
   input  logic          llb_lvl_i,
   input  logic          llb_vld_i,
   input  logic [TW-1:0] intv_i,
   output logic          fire1_o,
   output logic          fire2_o
);
   logic [1:0]    want, st_q;
   logic [TW-1:0] cnt_q;
   logic          last;

   always_comb begin
      if (llb_vld_i && !llb_lvl_i)     want = 2'd2;
      else if (lb_vld_i && !lb_lvl_i)  want = 2'd1;
      else                             want = 2'd0;
   end

   assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, intv_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q  <= 2'd0;
         cnt_q <= '0;
      end else if (want != st_q) begin
         st_q  <= want;
         cnt_q <= '0;
      end else if (st_q != 2'd0 && tick_i) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

   assign fire1_o = (st_q == 2'd1) && (want == 2'd1) && tick_i && last;
   assign fire2_o = (st_q == 2'd2) && (want == 2'd2) && tick_i && last;

   // R7: the first stage never fires while the second-stage input is low
   p_stage1_yields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire1_o |-> (llb_lvl_i || !llb_vld_i));
endmodule

// File: rtl/pm_smi_drive.sv
module pm_smi_drive import pm_smi_pkg::*; #(
   parameter int TW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic [1:0]    mode_i,
   input  logic [TW-1:0] len_i,
   input  logic          set_any_i,
   input  logic          pend_any_i,
   output logic          act_o
);
   smi_mode_e     mode;
   logic          act_q, last;
   logic [TW-1:0] cnt_q;

   assign mode = smi_mode_e'(mode_i);
   assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         case (mode)
            SMI_HOLD: act_q <= pend_any_i;
            SMI_HOLD_TMO: begin
               if (set_any_i) begin
                  act_q <= 1'b1;
                  cnt_q <= '0;
               end else if (act_q && (!pend_any_i || (tick_i && last))) begin
                  act_q <= 1'b0;
               end else if (act_q && tick_i) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (set_any_i) begin
                  act_q <= 1'b1;
                  cnt_q <= '0;
               end else if (act_q && tick_i && last) begin
                  act_q <= 1'b0;
               end else if (act_q && tick_i) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign act_o = act_q;

   // R10: in timeout mode, clearing every pending bit ends the interrupt
   p_tmo_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == SMI_HOLD_TMO && act_q && !pend_any_i) |=> !act_q);

   // R11: an active pulse never runs past its programmed length
   p_pulse_bounded_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q && (mode == SMI_PULSE || mode == SMI_PULSE_ALT) && $stable(len_i))
      |-> ({1'b0, cnt_q} < {1'b0, len_i}));
endmodule

// File: rtl/pm_smi_ctrl.sv
module pm_smi_ctrl import pm_smi_pkg::*; #(
   parameter int NB       = 7,
   parameter int DB_TICKS = 4,
   parameter int RW       = 4,
   parameter int TW       = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic            sys_asleep_i,
   input  logic [NB-1:0]   evt_i,
   input  logic            hotkey_n_i,
   input  logic            rtc_i,
   input  logic            drq_i,
   input  logic            ring_i,
   input  logic            lb_n_i,
   input  logic            llb_n_i,
   input  logic            ext_smi_i,
   input  logic [RW-1:0]   ring_target_i,
   input  logic [TW-1:0]   batt_intv_i,
   input  logic [1:0]      smi_mode_i,
   input  logic [TW-1:0]   smi_len_i,
   input  logic            smi_act_high_i,
   input  logic            clr_stb_i,
   input  logic [NB+5:0]   clr_mask_i,
   output logic [NB+5:0]   status_o,
   output logic            wake_o,
   output logic            smi_o
);
   localparam int SW       = NB + 6;
   localparam int IDX_HOT  = NB;
   localparam int IDX_RTC  = NB + 1;
   localparam int IDX_DRQ  = NB + 2;
   localparam int IDX_RING = NB + 3;
   localparam int IDX_LB1  = NB + 4;
   localparam int IDX_LB2  = NB + 5;

   initial assert (NB >= 1 && RW >= 1 && TW >= 2) else $error("bad width parameters");

   logic [SW-1:0] set_vec, status_q, status_d, clr_eff, keep;
   logic [NB-1:0] evt_lvl, evt_vld, evt_edge;
   logic hot_lvl, hot_vld, hot_fall;
   logic rtc_lvl, rtc_vld, rtc_rise;
   logic drq_lvl, drq_vld, drq_rise;
   logic rng_lvl, rng_vld, rng_rise;
   logic lb_lvl, lb_vld, llb_lvl, llb_vld;
   logic fire1, fire2, ring_hit, wake_q, smi_act, smi_any;
   logic [RW-1:0] ring_cnt_q;

   generate
      for (genvar g = 0; g < NB; g++) begin : g_evt
         pm_in_filter #(.DEBOUNCE(1'b1), .DB_TICKS(DB_TICKS)) u_flt (
            .clk_i, .rst_ni, .tick_i, .raw_i(evt_i[g]),
            .lvl_o(evt_lvl[g]), .vld_o(evt_vld[g]));
         pm_edge_pick #(.EDGE(EDGE_BOTH)) u_edge (
            .clk_i, .rst_ni, .lvl_i(evt_lvl[g]), .vld_i(evt_vld[g]),
            .pulse_o(evt_edge[g]));
      end
   endgenerate

   pm_in_filter #(.DEBOUNCE(1'b1), .DB_TICKS(DB_TICKS)) u_hot_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(hotkey_n_i), .lvl_o(hot_lvl), .vld_o(hot_vld));
   pm_edge_pick #(.EDGE(EDGE_FALL)) u_hot_edge (
      .clk_i, .rst_ni, .lvl_i(hot_lvl), .vld_i(hot_vld), .pulse_o(hot_fall));

   pm_in_filter #(.DEBOUNCE(1'b0), .DB_TICKS(DB_TICKS)) u_rtc_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(rtc_i), .lvl_o(rtc_lvl), .vld_o(rtc_vld));
   pm_edge_pick #(.EDGE(EDGE_RISE)) u_rtc_edge (
      .clk_i, .rst_ni, .lvl_i(rtc_lvl), .vld_i(rtc_vld), .pulse_o(rtc_rise));

   pm_in_filter #(.DEBOUNCE(1'b0), .DB_TICKS(DB_TICKS)) u_drq_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(drq_i), .lvl_o(drq_lvl), .vld_o(drq_vld));
   pm_edge_pick #(.EDGE(EDGE_RISE)) u_drq_edge (
      .clk_i, .rst_ni, .lvl_i(drq_lvl), .vld_i(drq_vld), .pulse_o(drq_rise));

   pm_in_filter #(.DEBOUNCE(1'b0), .DB_TICKS(DB_TICKS)) u_rng_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(ring_i), .lvl_o(rng_lvl), .vld_o(rng_vld));
   pm_edge_pick #(.EDGE(EDGE_RISE)) u_rng_edge (
      .clk_i, .rst_ni, .lvl_i(rng_lvl), .vld_i(rng_vld), .pulse_o(rng_rise));

   pm_in_filter #(.DEBOUNCE(1'b0), .DB_TICKS(DB_TICKS)) u_lb_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(lb_n_i), .lvl_o(lb_lvl), .vld_o(lb_vld));
   pm_in_filter #(.DEBOUNCE(1'b0), .DB_TICKS(DB_TICKS)) u_llb_flt (
      .clk_i, .rst_ni, .tick_i, .raw_i(llb_n_i), .lvl_o(llb_lvl), .vld_o(llb_vld));

   pm_batt_warn #(.TW(TW)) u_batt (
      .clk_i, .rst_ni, .tick_i,
      .lb_lvl_i(lb_lvl), .lb_vld_i(lb_vld), .llb_lvl_i(llb_lvl), .llb_vld_i(llb_vld),
      .intv_i(batt_intv_i), .fire1_o(fire1), .fire2_o(fire2));

   // ring counter: only counts while the system is in a low-power state
   assign ring_hit = sys_asleep_i & rng_rise &
                     (({1'b0, ring_cnt_q} + 1'b1) >= {1'b0, ring_target_i});

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !sys_asleep_i) ring_cnt_q <= '0;
      else if (rng_rise)            ring_cnt_q <= ring_hit ? '0 : ring_cnt_q + 1'b1;
   end

   always_comb begin
      set_vec                = '0;
      set_vec[NB-1:0]        = evt_edge;
      set_vec[IDX_HOT]       = hot_fall;
      set_vec[IDX_RTC]       = rtc_rise & sys_asleep_i;
      set_vec[IDX_DRQ]       = drq_rise & sys_asleep_i;
      set_vec[IDX_RING]      = ring_hit;
      set_vec[IDX_LB1]       = fire1;
      set_vec[IDX_LB2]       = fire2;
   end

   assign clr_eff  = clr_stb_i ? clr_mask_i : '0;
   assign keep     = status_q & ~clr_eff;
   assign status_d = keep | set_vec;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         status_q <= '0;
         wake_q   <= 1'b0;
      end else begin
         status_q <= status_d;
         wake_q   <= set_vec[IDX_RTC] | set_vec[IDX_DRQ] | set_vec[IDX_RING];
      end
   end

   pm_smi_drive #(.TW(TW)) u_drive (
      .clk_i, .rst_ni, .tick_i, .mode_i(smi_mode_i), .len_i(smi_len_i),
      .set_any_i(|set_vec), .pend_any_i(|status_d), .act_o(smi_act));

   assign smi_any  = smi_act | ext_smi_i;
   assign smi_o    = smi_act_high_i ? smi_any : ~smi_any;
   assign status_o = status_q;
   assign wake_o   = wake_q;

   // R8: a bit that was not cleared stays set
   p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((status_q & $past(keep)) == $past(keep)));

   // R4: a wake request follows only a cycle spent in a low-power state
   p_wake_asleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> $past(sys_asleep_i));

   // R9: in hold mode the interrupt is active whenever a bit is pending
   p_level_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smi_mode_i == 2'd0 && $past(smi_mode_i) == 2'd0 && (|status_q)) |-> smi_act);
endmodule

// File: tb/pm_smi_ctrl_bench.sv
module pm_smi_ctrl_bench;
   localparam int NB = 7;
   localparam int SW = NB + 6;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, asleep = 1'b0;
   logic [NB-1:0] evt = '0;
   logic hot_n = 1'b1, rtc = 1'b0, drq = 1'b0, ring = 1'b0, lb_n = 1'b1, llb_n = 1'b1, ext = 1'b0;
   logic [3:0] ring_tgt = 4'd3;
   logic [7:0] intv = 8'd10, slen = 8'd20;
   logic [1:0] mode = 2'd0;
   logic act_hi = 1'b1, clr = 1'b0;
   logic [SW-1:0] cmask = '0, status;
   logic wake, smi;

   int n_chk = 0, n_err = 0, wake_cnt = 0, run_cur = 0, last_run = 0;
   bit done = 0;

   typedef struct { string tag; int sel; int exp; } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   pm_smi_ctrl #(.NB(NB)) u_pm_smi_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sys_asleep_i(asleep), .evt_i(evt),
      .hotkey_n_i(hot_n), .rtc_i(rtc), .drq_i(drq), .ring_i(ring), .lb_n_i(lb_n),
      .llb_n_i(llb_n), .ext_smi_i(ext), .ring_target_i(ring_tgt), .batt_intv_i(intv),
      .smi_mode_i(mode), .smi_len_i(slen), .smi_act_high_i(act_hi), .clr_stb_i(clr),
      .clr_mask_i(cmask), .status_o(status), .wake_o(wake), .smi_o(smi));

   always @(negedge clk) begin
      if (rst_n && wake) wake_cnt++;
      if (smi) run_cur++;
      else if (run_cur > 0) begin last_run = run_cur; run_cur = 0; end
   end

   function automatic int observe(int sel);
      case (sel)
         0: return int'(status);
         1: return int'(smi);
         2: return wake_cnt;
         default: return last_run;
      endcase
   endfunction

   // monitor: pops every queued expectation at the next falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         int obs;
         it  = sb_q.pop_front();
         obs = observe(it.sel);
         n_chk++;
         if (obs != it.exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, obs, it.exp);
         end
      end
   end

   task automatic expect_item(string tag, int sel, int exp);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_bits(logic [SW-1:0] m);
      cmask = m; clr = 1'b1;
      cyc(1);
      clr = 1'b0; cmask = '0;
      cyc(1);
   endtask

   task automatic ring_pulse();
      ring = 1'b1; cyc(3);
      ring = 1'b0; cyc(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: got 0 expected 1 (run ended)");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(10);
      expect_item("R8 reset status", 0, 0);
      expect_item("R9 reset smi", 1, 0);
      expect_item("R4 reset wake", 2, 0);
      cyc(2);

      // R1: both edges of a filtered input
      evt[2] = 1'b1; cyc(12);
      expect_item("R1 rise sets bit2", 0, 1 << 2); cyc(2);
      clear_bits('1);
      evt[2] = 1'b0; cyc(12);
      expect_item("R1 fall sets bit2", 0, 1 << 2); cyc(2);
      clear_bits('1);

      // R2: three-tick glitch rejected
      evt[0] = 1'b1; cyc(3); evt[0] = 1'b0; cyc(12);
      expect_item("R2 short glitch ignored", 0, 0); cyc(2);

      // R3: hotkey falling only
      hot_n = 1'b0; cyc(12);
      expect_item("R3 hotkey press", 0, 1 << NB); cyc(2);
      clear_bits('1);
      hot_n = 1'b1; cyc(12);
      expect_item("R3 hotkey release ignored", 0, 0); cyc(2);

      // R4: alarm while awake ignored, DMA request while asleep wakes
      rtc = 1'b1; cyc(8);
      expect_item("R4 awake alarm ignored", 0, 0);
      expect_item("R4 awake no wake", 2, 0); cyc(2);
      rtc = 1'b0; cyc(4);
      asleep = 1'b1; cyc(2);
      drq = 1'b1; cyc(8);
      expect_item("R4 asleep dma sets bit", 0, 1 << (NB + 2));
      expect_item("R4 asleep dma wakes", 2, 1); cyc(2);
      drq = 1'b0;
      clear_bits('1);

      // R5: ring counting
      ring_pulse(); ring_pulse(); cyc(4);
      expect_item("R5 two rings not enough", 0, 0); cyc(2);
      ring_pulse(); cyc(4);
      expect_item("R5 third ring sets bit", 0, 1 << (NB + 3));
      expect_item("R5 third ring wakes", 2, 2); cyc(2);
      clear_bits('1);
      asleep = 1'b0; cyc(2);
      ring_pulse(); ring_pulse();
      asleep = 1'b1; cyc(2);
      ring_pulse(); cyc(4);
      expect_item("R5 awake rings not counted", 0, 0); cyc(2);
      ring_pulse(); ring_pulse(); cyc(4);
      expect_item("R5 count restarted", 0, 1 << (NB + 3)); cyc(2);
      asleep = 1'b0;
      clear_bits('1);

      // R6: first stage repeats
      lb_n = 1'b0; cyc(18);
      expect_item("R6 stage1 fires", 0, 1 << (NB + 4)); cyc(1);
      clear_bits('1);
      cyc(10);
      expect_item("R6 stage1 repeats", 0, 1 << (NB + 4)); cyc(1);

      // R7: second stage takes over
      llb_n = 1'b0; cyc(4);
      clear_bits('1);
      cyc(15);
      expect_item("R7 stage2 only", 0, 1 << (NB + 5)); cyc(1);
      lb_n = 1'b1; llb_n = 1'b1; cyc(6);
      clear_bits('1);
      cyc(25);
      expect_item("R6 no battery warning when high", 0, 0); cyc(2);

      // R8: masked clear
      evt[0] = 1'b1; evt[1] = 1'b1; cyc(12);
      expect_item("R8 two bits set", 0, 3); cyc(1);
      clear_bits(1);
      expect_item("R8 masked clear", 0, 2); cyc(2);

      // R9: hold mode
      expect_item("R9 hold asserted", 1, 1); cyc(30);
      expect_item("R9 still held", 1, 1); cyc(1);
      clear_bits('1);
      expect_item("R9 released after clear", 1, 0); cyc(2);

      // R10: hold with timeout
      mode = 2'd1; slen = 8'd20; cyc(2);
      evt[1] = 1'b0; cyc(40);
      expect_item("R10 timeout length", 3, 20);
      expect_item("R10 status kept", 0, 2);
      expect_item("R10 released", 1, 0); cyc(2);
      clear_bits('1);
      evt[1] = 1'b1; cyc(12);
      expect_item("R10 active before timeout", 1, 1); cyc(1);
      clear_bits('1);
      expect_item("R10 early release by clear", 1, 0); cyc(2);

      // R11: pulse mode
      mode = 2'd2; slen = 8'd5; cyc(2);
      evt[0] = 1'b0; cyc(20);
      expect_item("R11 pulse length", 3, 5);
      expect_item("R11 status independent", 0, 1); cyc(2);
      clear_bits('1);
      mode = 2'd3; slen = 8'd7; cyc(2);
      evt[0] = 1'b1; cyc(20);
      expect_item("R11 alt pulse length", 3, 7); cyc(2);
      clear_bits('1);

      // R12: polarity and external request
      mode = 2'd0; cyc(3);
      act_hi = 1'b0; cyc(1);
      expect_item("R12 idle active-low", 1, 1); cyc(1);
      ext = 1'b1; cyc(1);
      expect_item("R12 ext active-low", 1, 0); cyc(1);
      act_hi = 1'b1; cyc(1);
      expect_item("R12 ext active-high", 1, 1); cyc(1);
      ext = 1'b0; cyc(1);
      expect_item("R12 idle active-high", 1, 0); cyc(3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule